// File: doc/BRIEF.md
# Emergency Output Shutdown Controller

This block stands between a motor-control timer and its six high-drive output pins. When a fault is seen, it removes the drive from all six pins at once by pulling down a per-pin output-enable. There are two fault sources. The first is any of four active-low fault-request inputs that shows a falling edge while its detection is enabled. The second is an output-level compare that sees both pins of a complementary pair driven high while the compare is enabled.

Each fault is latched in a sticky flag. The pins stay in high impedance until every flag is released under its own rule. Input flags are released by software through a read-then-write-zero sequence. The output flag is released only after the compare is disabled and all six pins are already driving high. An asynchronous reset releases everything.

Software reaches two 16-bit registers through a simple strobe interface with a one-bit register select. Reads return data combinationally in the strobe cycle. Writes take effect at the clock edge.

Top module: `pin_shutdown_ctrl`

## Requirements
- R1: After reset, all six `pin_oe_o` bits are 1. The input register (select 0) reads 0x0000. The output register (select 1) reads 0x0000.
- R2: The input register holds four fault flags at bits 15..12 and four detect enables at bits 3..0, one pair per input. Flag k sits at bit 12+k and is set by a falling edge on `fault_req_ni[k]` while enable k is 1. All six `pin_oe_o` bits go to 0 at the third rising clock edge after the input changes.
- R3: A falling edge on a fault input whose detect enable is 0 sets no flag and leaves `pin_oe_o` at all ones.
- R4: A set flag stays set after its fault input returns high.
- R5: Writing 0 to a flag bit clears it only if that flag was read as 1 from the same register since the last write to that register. Writing 1 never clears a flag. A write without a preceding read clears nothing.
- R6: High impedance from input faults ends only when all four input flags are clear. While any flag remains set, `pin_oe_o` stays all zeros.
- R7: The output register holds the compare enable at bit 9 and the output fault flag at bit 15. The pin pairs are (0,1), (2,3) and (4,5). When the enable is 1 and both pins of any pair are driven high, the flag sets at the next clock edge and all `pin_oe_o` bits go to 0.
- R8: With the compare enable at 0, conflicting pairs set no output flag and do not change `pin_oe_o`.
- R9: A write-zero clear of the output flag, made after reading the flag as 1, takes effect only if two conditions hold at that write: the compare enable was already 0, and all six `pin_drive_i` bits are 1. Otherwise the flag stays set.
- R10: Asserting `rst_ni` low releases all pins at once, without waiting for a clock, and clears every flag and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_req_ni | input | 4 | Active-low fault-request inputs, asynchronous |
| pin_drive_i | input | 6 | Values the timer drives onto the six pins |
| reg_sel_i | input | 1 | Register select: 0 input register, 1 output register |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| pin_oe_o | output | 6 | Per-pin output enable, 0 means high impedance |

## Verification
The assertions assume the following about the inputs:
- Read and write strobes are never asserted in the same cycle.
- Strobes and `pin_drive_i` are synchronous to `clk_i`.
- A fault input is high whenever its detect enable is switched on, so that no false edge is captured.

The stimulus changes inputs one nanosecond after a rising edge. It issues single-cycle strobes one at a time. It returns each fault input high before the next edge is applied, which keeps every run inside those assumptions. A behavioural model in the bench follows every clock, so interleavings of the two fault sources, partial clears and premature clears are all compared against the expected pin state.

// File: rtl/eos_pkg.sv
`timescale 1ns/1ps
package eos_pkg;
  localparam int REG_W          = 16;
  localparam int IN_FLAG_LSB    = 12;
  localparam int OUT_FLAG_BIT   = 15;
  localparam int OUT_CMP_EN_BIT = 9;

  typedef enum logic {
    REG_IN_STAT  = 1'b0,
    REG_OUT_STAT = 1'b1
  } eos_reg_e;
endpackage

// File: rtl/eos_sync.sv
`timescale 1ns/1ps
module eos_sync #(
  parameter int   W       = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eos_in_det.sv
`timescale 1ns/1ps
module eos_in_det #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] fault_n_i,
  input  logic [N-1:0] det_en_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] lvl, prev_q, fall, flag_q, arm_q;

  eos_sync #(.W(N), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fault_n_i),
    .q_o    (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl & det_en_i;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        // detection wins over a clear landing in the same cycle
        if (fall[i])                             flag_q[i] <= 1'b1;
        else if (wr_i && arm_q[i] && !keep_i[i]) flag_q[i] <= 1'b0;
        if (wr_i)      arm_q[i] <= 1'b0;
        else if (rd_i) arm_q[i] <= flag_q[i];
      end
    end

    a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !wr_i) |=> flag_q[i]);
    a_r5_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && wr_i && keep_i[i]) |=> flag_q[i]);
    a_r3_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(det_en_i[i]));
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/eos_out_det.sv
`timescale 1ns/1ps
module eos_out_det #(
  parameter int NPAIR = 3,
  localparam int NPIN = 2 * NPAIR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_drive_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            keep_i,
  input  logic            en_wdata_i,
  output logic            flag_o,
  output logic            cmp_en_o
);
  logic [NPAIR-1:0] pair_hit;
  logic flag_q, arm_q, cmp_en_q, all_high, clr_ok;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_hit[p] = pin_drive_i[2*p] & pin_drive_i[2*p+1];
  end

  assign all_high = &pin_drive_i;
  // compare must already be off and every pin driving high
  assign clr_ok   = wr_i && arm_q && !keep_i && !cmp_en_q && all_high;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      arm_q    <= 1'b0;
      cmp_en_q <= 1'b0;
    end else begin
      if (cmp_en_q && |pair_hit) flag_q <= 1'b1;
      else if (clr_ok)           flag_q <= 1'b0;
      if (wr_i)      arm_q <= 1'b0;
      else if (rd_i) arm_q <= flag_q;
      if (wr_i) cmp_en_q <= en_wdata_i;
    end
  end

  a_r9_clear_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(!cmp_en_q && all_high && wr_i));
  a_r8_set_needs_cmp_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(cmp_en_q));

  assign flag_o   = flag_q;
  assign cmp_en_o = cmp_en_q;
endmodule

// File: rtl/pin_shutdown_ctrl.sv
`timescale 1ns/1ps
module pin_shutdown_ctrl
  import eos_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int NUM_PAIR = 3,
  localparam int NUM_PIN = 2 * NUM_PAIR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  fault_req_ni,
  input  logic [NUM_PIN-1:0] pin_drive_i,
  input  logic               reg_sel_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic [NUM_PIN-1:0] pin_oe_o
);
  logic sel_out, rd_in, wr_in, rd_out, wr_out;
  logic [NUM_IN-1:0] det_en_q, in_flags;
  logic out_flag, cmp_en, hiz;
  logic unused_wdata;

  assign sel_out = (eos_reg_e'(reg_sel_i) == REG_OUT_STAT);
  assign rd_in   = reg_rd_i && !sel_out;
  assign wr_in   = reg_wr_i && !sel_out;
  assign rd_out  = reg_rd_i && sel_out;
  assign wr_out  = reg_wr_i && sel_out;
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    det_en_q <= '0;
    else if (wr_in) det_en_q <= reg_wdata_i[NUM_IN-1:0];
  end

  eos_in_det #(.N(NUM_IN)) u_in_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_n_i (fault_req_ni),
    .det_en_i  (det_en_q),
    .rd_i      (rd_in),
    .wr_i      (wr_in),
    .keep_i    (reg_wdata_i[IN_FLAG_LSB +: NUM_IN]),
    .flags_o   (in_flags)
  );

  eos_out_det #(.NPAIR(NUM_PAIR)) u_out_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_drive_i (pin_drive_i),
    .rd_i        (rd_out),
    .wr_i        (wr_out),
    .keep_i      (reg_wdata_i[OUT_FLAG_BIT]),
    .en_wdata_i  (reg_wdata_i[OUT_CMP_EN_BIT]),
    .flag_o      (out_flag),
    .cmp_en_o    (cmp_en)
  );

  assign hiz      = (|in_flags) | out_flag;
  assign pin_oe_o = {NUM_PIN{~hiz}};

  always_comb begin
    reg_rdata_o = '0;
    if (sel_out) begin
      reg_rdata_o[OUT_FLAG_BIT]   = out_flag;
      reg_rdata_o[OUT_CMP_EN_BIT] = cmp_en;
    end else begin
      reg_rdata_o[IN_FLAG_LSB +: NUM_IN] = in_flags;
      reg_rdata_o[NUM_IN-1:0]            = det_en_q;
    end
  end

  a_r6_release_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o[0]) |-> $past(reg_wr_i));
  a_r2_pins_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pin_oe_o) == 0 || $countones(pin_oe_o) == NUM_PIN);
endmodule

// File: tb/pin_shutdown_ctrl_bench.sv
`timescale 1ns/1ps
module pin_shutdown_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  fault_n = 4'hF;
  logic [5:0]  drive = '0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  oe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pin_shutdown_ctrl u_pin_shutdown_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fault_req_ni(fault_n), .pin_drive_i(drive),
    .reg_sel_i(sel), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pin_oe_o(oe)
  );

  // behavioural reference model
  bit m_s1[4], m_s2[4], m_pv[4], m_fl[4], m_ar[4], m_en[4];
  bit m_of, m_oa, m_oce;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_pv[i] = 1; m_fl[i] = 0; m_ar[i] = 0; m_en[i] = 0;
      end
      m_of = 0; m_oa = 0; m_oce = 0;
    end else begin
      bit hit, allhi, nfl, nar;
      for (int i = 0; i < 4; i++) begin
        if (m_en[i] && m_pv[i] && !m_s2[i]) nfl = 1;
        else if (wr && !sel && m_ar[i] && !wdata[12+i]) nfl = 0;
        else nfl = m_fl[i];
        if (wr && !sel) nar = 0;
        else if (rd && !sel) nar = m_fl[i];
        else nar = m_ar[i];
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = fault_n[i];
        m_fl[i] = nfl; m_ar[i] = nar;
      end
      if (wr && !sel) for (int i = 0; i < 4; i++) m_en[i] = wdata[i];
      hit   = (drive[0] && drive[1]) || (drive[2] && drive[3]) || (drive[4] && drive[5]);
      allhi = (drive == 6'h3F);
      if (m_oce && hit) nfl = 1;
      else if (wr && sel && m_oa && !wdata[15] && !m_oce && allhi) nfl = 0;
      else nfl = m_of;
      if (wr && sel) nar = 0;
      else if (rd && sel) nar = m_of;
      else nar = m_oa;
      if (wr && sel) m_oce = wdata[9];
      m_of = nfl; m_oa = nar;
    end
  end

  function automatic logic [5:0] exp_oe();
    bit any = m_of;
    for (int i = 0; i < 4; i++) any |= m_fl[i];
    return any ? 6'h00 : 6'h3F;
  endfunction

  function automatic logic [15:0] exp_rdata();
    logic [15:0] v = '0;
    if (sel) begin v[15] = m_of; v[9] = m_oce; end
    else for (int i = 0; i < 4; i++) begin v[12+i] = m_fl[i]; v[i] = m_en[i]; end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(oe == exp_oe(), "R2 R6 R7 model oe", oe, exp_oe());
      chk(rdata == exp_rdata(), "R5 R9 model rdata", rdata, exp_rdata());
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; rd = 0; wr = 0; end
  endtask

  task automatic set_in(input logic [3:0] f, input logic [5:0] d);
    @(posedge clk); #1; rd = 0; wr = 0; fault_n = f; drive = d;
  endtask

  task automatic wr_reg(input bit s, input logic [15:0] d);
    @(posedge clk); #1; rd = 0; wr = 1; sel = s; wdata = d;
  endtask

  task automatic rd_reg(input bit s, output logic [15:0] v);
    @(posedge clk); #1; wr = 0; rd = 1; sel = s;
    @(negedge clk); v = rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    int n;
    idle(3);
    chk(oe == 6'h3F, "R1 oe in reset", oe, 6'h3F);
    @(posedge clk); #1 rst_n = 1;
    rd_reg(0, v); chk(v == 16'h0000, "R1 input reg", v, 0);
    rd_reg(1, v); chk(v == 16'h0000, "R1 output reg", v, 0);

    // R3: edge with detection disabled
    set_in(4'b1110, 6'h00); idle(5);
    chk(oe == 6'h3F, "R3 oe", oe, 6'h3F);
    rd_reg(0, v); chk(v == 16'h0000, "R3 flags", v, 0);
    set_in(4'hF, 6'h00); idle(3);

    wr_reg(0, 16'h000F); idle(2);
    // R2: latency to high impedance
    set_in(4'b1011, 6'h00);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); n++;
      if (oe == 6'h00) break;
    end
    chk(n == 4, "R2 three-edge latency", n, 4);
    rd_reg(0, v); chk(v == 16'h400F, "R2 flag bit 14", v, 16'h400F);

    // R4: sticky after input returns high
    set_in(4'hF, 6'h00); idle(4);
    rd_reg(0, v); chk(v == 16'h400F, "R4 sticky", v, 16'h400F);
    chk(oe == 6'h00, "R4 oe held", oe, 0);

    // R5: write 1 keeps, write 0 without read ignored
    wr_reg(0, 16'hF00F); wr_reg(0, 16'h000F); idle(1);
    rd_reg(0, v); chk(v == 16'h400F, "R5 unarmed clear ignored", v, 16'h400F);

    // R6: partial clear keeps pins off
    set_in(4'b1101, 6'h00); idle(4); set_in(4'hF, 6'h00); idle(3);
    rd_reg(0, v); chk(v == 16'h600F, "R2 second flag", v, 16'h600F);
    wr_reg(0, 16'h200F); idle(1);
    chk(oe == 6'h00, "R6 partial clear", oe, 0);
    rd_reg(0, v); chk(v == 16'h200F, "R5 armed clear", v, 16'h200F);
    wr_reg(0, 16'h000F); idle(1);
    chk(oe == 6'h3F, "R6 full release", oe, 6'h3F);

    // R8: compare disabled
    set_in(4'hF, 6'b000011); idle(4);
    chk(oe == 6'h3F, "R8 oe", oe, 6'h3F);
    rd_reg(1, v); chk(v == 16'h0000, "R8 flag", v, 0);

    // R7: compare enabled with conflicting pair
    wr_reg(1, 16'h0200); idle(2);
    chk(oe == 6'h00, "R7 oe", oe, 0);
    rd_reg(1, v); chk(v == 16'h8200, "R7 flag", v, 16'h8200);

    // R9: clear rules for the output flag
    set_in(4'hF, 6'h3F);
    rd_reg(1, v);
    wr_reg(1, 16'h0000); idle(1);
    rd_reg(1, v); chk(v == 16'h8000, "R9 clear with compare on", v, 16'h8000);
    set_in(4'hF, 6'b101010);
    wr_reg(1, 16'h0000); idle(1);
    rd_reg(1, v); chk(v == 16'h8000, "R9 clear with pins low", v, 16'h8000);
    set_in(4'hF, 6'h3F);
    wr_reg(1, 16'h0000); idle(1);
    rd_reg(1, v); chk(v == 16'h0000, "R9 valid clear", v, 0);
    chk(oe == 6'h3F, "R9 release", oe, 6'h3F);
    set_in(4'hF, 6'h00);

    // R10: asynchronous reset mid-fault
    set_in(4'b0111, 6'h00); idle(4);
    chk(oe == 6'h00, "R10 fault before reset", oe, 0);
    @(posedge clk); #1 rst_n = 0;
    #0.5 chk(oe == 6'h3F, "R10 async release", oe, 6'h3F);
    idle(2); fault_n = 4'hF;
    @(posedge clk); #1 rst_n = 1;
    idle(2);
    rd_reg(0, v); chk(v == 16'h0000, "R10 input reg", v, 0);
    rd_reg(1, v); chk(v == 16'h0000, "R10 output reg", v, 0);
    idle(2);
    summary();
  end
endmodule